// File: doc/BRIEF.md
# Thread-Block Residency Admission Controller

This block guards the resources of one compute cluster that runs thread blocks. For each launch request it decides whether one more block fits beside the blocks already resident. A request gives the thread count of the block, the registers each thread needs and the shared memory the block needs. The controller keeps five running totals: register entries, shared-memory bytes, warp slots, thread slots and block slots. A request is granted only when every total stays within its limit after the new block is added. On a grant the block's cost is reserved at the next clock edge.

A release port returns the cost of a block that has finished. The caller presents the same three figures the block was granted with. A grant and a release in the same cycle are both applied, and the admission check already counts the released resources as free. The number of resident warps is reported as the occupancy figure. Occupancy is this count divided by the 64-warp ceiling.

Top module: `cta_admit_ctrl`

## Requirements
- R1: A request is granted only if the registers in use, plus warps-per-block × 32 × registers-per-thread, stay at or below 65,536. For example, 512 threads at 128 registers per thread consume the whole file.
- R2: Warps per block is the thread count divided by 32, rounded up. Warp slots are charged by this value and thread slots by this value × 32, so a 33-thread block takes 2 warps.
- R3: A request is granted only if resident warps stay at or below 64 and charged threads stay at or below 2048.
- R4: A request is granted only if resident blocks stay at or below 32.
- R5: A request is granted only if reserved shared memory stays at or below 233,472 bytes.
- R6: A request asking for more than 255 registers per thread is never granted.
- R7: After a grant, every total rises by the block's cost at the next clock edge. After a release, every total falls by that cost. When both happen in one cycle, both are applied and the check sees the totals after the release.
- R8: A request with zero threads is not granted. `req_err` is high in the same cycle, and no total changes.
- R9: `resident_warps` reports the warp slots in use, so occupancy is resident_warps / 64. After reset every total reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Launch request present |
| req_threads | input | 12 | Threads in the requested block |
| req_regs | input | 9 | Registers per thread requested |
| req_smem | input | 18 | Shared-memory bytes for the block |
| rel_valid | input | 1 | A finished block returns its resources |
| rel_threads | input | 12 | Thread count the finished block was granted with |
| rel_regs | input | 9 | Registers per thread of the finished block |
| rel_smem | input | 18 | Shared-memory bytes of the finished block |
| grant | output | 1 | Request admitted (combinational, same cycle) |
| req_err | output | 1 | Request has zero threads |
| resident_warps | output | 7 | Warp slots in use (occupancy numerator) |
| resident_blocks | output | 6 | Blocks resident |
| regs_in_use | output | 17 | Register entries reserved |
| smem_in_use | output | 18 | Shared-memory bytes reserved |

## Verification
Each limit is driven to exactly full while the other four stay slack, then probed with one more unit. A failing check therefore points at the single comparison that is wrong, and exact-fit cases separate an off-by-one bound from a correct one. A 33-thread request tells warp rounding apart from truncation. A 255 versus 256 registers-per-thread pair pins the per-thread cap. A full block table with a simultaneous release and request shows whether the check uses the totals after the release. A zero-thread request confirms that the error flag rises and no total moves.

// File: rtl/cta_admit_pkg.sv
// Package: shared limits, derived widths and the per-block cost record
// for the residency admission controller.
package cta_admit_pkg;
    localparam int LANES        = 32;
    localparam int REG_ENTRIES  = 65536;
    localparam int MAX_WARPS    = 64;
    localparam int MAX_THREADS  = 2048;
    localparam int MAX_BLOCKS   = 32;
    localparam int SMEM_BYTES   = 233472;
    localparam int MAX_RPT      = 255;

    localparam int REQ_THR_W    = 12;
    localparam int REQ_REG_W    = 9;
    localparam int LANE_SH      = $clog2(LANES);
    localparam int SMEM_W       = $clog2(SMEM_BYTES + 1);
    localparam int REG_W        = $clog2(REG_ENTRIES + 1);
    localparam int WARP_W       = $clog2(MAX_WARPS + 1);
    localparam int THR_W        = $clog2(MAX_THREADS + 1);
    localparam int BLK_W        = $clog2(MAX_BLOCKS + 1);
    localparam int REQ_WARP_W   = REQ_THR_W - LANE_SH + 1;
    localparam int COST_REG_W   = REQ_WARP_W + LANE_SH + REQ_REG_W;
    localparam int NRES         = 5;

    // Resources one block consumes, sized for any request value.
    typedef struct packed {
        logic [REQ_WARP_W-1:0] warps;
        logic [REQ_THR_W:0]    threads;
        logic [COST_REG_W-1:0] regs;
        logic [SMEM_W-1:0]     smem;
    } cost_t;
endpackage

// File: rtl/cta_cost_calc.sv
// Module: cta_cost_calc
// Converts a block description into the resources it consumes: warps
// rounded up from threads, thread slots as whole warps, registers per warp
// times warps. Purely combinational; assumes nothing about limits.
module cta_cost_calc
    import cta_admit_pkg::*;
(
    input  logic [REQ_THR_W-1:0] threads,
    input  logic [REQ_REG_W-1:0] regs_per_thr,
    input  logic [SMEM_W-1:0]    smem,
    output cost_t                cost
);
    logic [REQ_THR_W:0] thr_up;

    // Round threads up to whole warps and scale the per-thread registers.
    always_comb begin
        thr_up       = {1'b0, threads} + (REQ_THR_W + 1)'(LANES - 1);
        cost.warps   = thr_up[REQ_THR_W:LANE_SH];
        cost.threads = {cost.warps, {LANE_SH{1'b0}}};
        cost.regs    = (COST_REG_W'(cost.warps) * COST_REG_W'(regs_per_thr)) << LANE_SH;
        cost.smem    = smem;
    end
endmodule

// File: rtl/cta_budget_check.sv
// Module: cta_budget_check
// Compares each resource total plus a candidate block's cost against its
// limit; fits is high only when all limits hold. Assumes the totals given
// already reflect any release in the same cycle.
module cta_budget_check
    import cta_admit_pkg::*;
(
    input  logic [WARP_W-1:0] warps_used,
    input  logic [THR_W-1:0]  thr_used,
    input  logic [REG_W-1:0]  regs_used,
    input  logic [SMEM_W-1:0] smem_used,
    input  logic [BLK_W-1:0]  blk_used,
    input  cost_t             cost,
    output logic              fits
);
    localparam logic [31:0] LIMITS [NRES] = '{
        32'(MAX_WARPS), 32'(MAX_THREADS), 32'(REG_ENTRIES),
        32'(SMEM_BYTES), 32'(MAX_BLOCKS)};

    logic [31:0]     used_a [NRES];
    logic [31:0]     cost_a [NRES];
    logic [NRES-1:0] ok;

    // Gather the five totals and block costs into uniform-width lanes.
    always_comb begin
        used_a[0] = 32'(warps_used);  cost_a[0] = 32'(cost.warps);
        used_a[1] = 32'(thr_used);    cost_a[1] = 32'(cost.threads);
        used_a[2] = 32'(regs_used);   cost_a[2] = 32'(cost.regs);
        used_a[3] = 32'(smem_used);   cost_a[3] = 32'(cost.smem);
        used_a[4] = 32'(blk_used);    cost_a[4] = 32'd1;
    end

    for (genvar i = 0; i < NRES; i++) begin : g_lim
        // One bound comparison per resource.
        assign ok[i] = (used_a[i] + cost_a[i]) <= LIMITS[i];
    end

    assign fits = &ok;
endmodule

// File: rtl/cta_usage_tracker.sv
// Module: cta_usage_tracker
// Holds the five resource totals. A release is subtracted first (the
// post-release totals are exported for the admission check), then a grant
// is added. Assumes releases only return resources that were granted.
module cta_usage_tracker
    import cta_admit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  cost_t             take_cost,
    input  logic              give,
    input  cost_t             give_cost,
    output logic [WARP_W-1:0] warps_q,
    output logic [THR_W-1:0]  thr_q,
    output logic [REG_W-1:0]  regs_q,
    output logic [SMEM_W-1:0] smem_q,
    output logic [BLK_W-1:0]  blk_q,
    output logic [WARP_W-1:0] warps_pr,
    output logic [THR_W-1:0]  thr_pr,
    output logic [REG_W-1:0]  regs_pr,
    output logic [SMEM_W-1:0] smem_pr,
    output logic [BLK_W-1:0]  blk_pr
);
    // Totals after any same-cycle release.
    always_comb begin
        warps_pr = warps_q - (give ? give_cost.warps[WARP_W-1:0]  : '0);
        thr_pr   = thr_q   - (give ? give_cost.threads[THR_W-1:0] : '0);
        regs_pr  = regs_q  - (give ? give_cost.regs[REG_W-1:0]    : '0);
        smem_pr  = smem_q  - (give ? give_cost.smem               : '0);
        blk_pr   = blk_q   - (give ? BLK_W'(1)                    : '0);
    end

    // Register the totals, adding a granted block on top of the release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warps_q <= '0;
            thr_q   <= '0;
            regs_q  <= '0;
            smem_q  <= '0;
            blk_q   <= '0;
        end else begin
            warps_q <= warps_pr + (take ? take_cost.warps[WARP_W-1:0]  : '0);
            thr_q   <= thr_pr   + (take ? take_cost.threads[THR_W-1:0] : '0);
            regs_q  <= regs_pr  + (take ? take_cost.regs[REG_W-1:0]    : '0);
            smem_q  <= smem_pr  + (take ? take_cost.smem               : '0);
            blk_q   <= blk_pr   + (take ? BLK_W'(1)                    : '0);
        end
    end

    AST_REG_BOUND:  assert property (@(posedge clk) disable iff (!rst_n)
        32'(regs_q) <= REG_ENTRIES);                                   // R1
    AST_WARP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(warps_q) <= MAX_WARPS && 32'(thr_q) <= MAX_THREADS);       // R3
    AST_BLK_BOUND:  assert property (@(posedge clk) disable iff (!rst_n)
        32'(blk_q) <= MAX_BLOCKS);                                     // R4
    AST_SMEM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(smem_q) <= SMEM_BYTES);                                    // R5
    AST_THR_WARP:   assert property (@(posedge clk) disable iff (!rst_n)
        32'(thr_q) == 32'(warps_q) * LANES);                           // R2
endmodule

// File: rtl/cta_admit_ctrl.sv
// Module: cta_admit_ctrl (top)
// Admission controller for thread blocks on one compute cluster. Grants a
// request combinationally when its cost fits all five limits after any
// same-cycle release; reservation takes effect at the next clock edge.
// Assumes the release port echoes the figures a block was granted with.
module cta_admit_ctrl
    import cta_admit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [REQ_THR_W-1:0] req_threads,
    input  logic [REQ_REG_W-1:0] req_regs,
    input  logic [SMEM_W-1:0]    req_smem,
    input  logic                 rel_valid,
    input  logic [REQ_THR_W-1:0] rel_threads,
    input  logic [REQ_REG_W-1:0] rel_regs,
    input  logic [SMEM_W-1:0]    rel_smem,
    output logic                 grant,
    output logic                 req_err,
    output logic [WARP_W-1:0]    resident_warps,
    output logic [BLK_W-1:0]     resident_blocks,
    output logic [REG_W-1:0]     regs_in_use,
    output logic [SMEM_W-1:0]    smem_in_use
);
    cost_t             req_cost, rel_cost;
    logic              fits, shape_ok;
    logic [THR_W-1:0]  thr_q;
    logic [WARP_W-1:0] warps_pr;
    logic [THR_W-1:0]  thr_pr;
    logic [REG_W-1:0]  regs_pr;
    logic [SMEM_W-1:0] smem_pr;
    logic [BLK_W-1:0]  blk_pr;

    cta_cost_calc u_req_cost (
        .threads(req_threads), .regs_per_thr(req_regs),
        .smem(req_smem), .cost(req_cost));

    cta_cost_calc u_rel_cost (
        .threads(rel_threads), .regs_per_thr(rel_regs),
        .smem(rel_smem), .cost(rel_cost));

    cta_usage_tracker u_track (
        .clk(clk), .rst_n(rst_n),
        .take(grant), .take_cost(req_cost),
        .give(rel_valid), .give_cost(rel_cost),
        .warps_q(resident_warps), .thr_q(thr_q), .regs_q(regs_in_use),
        .smem_q(smem_in_use), .blk_q(resident_blocks),
        .warps_pr(warps_pr), .thr_pr(thr_pr), .regs_pr(regs_pr),
        .smem_pr(smem_pr), .blk_pr(blk_pr));

    cta_budget_check u_check (
        .warps_used(warps_pr), .thr_used(thr_pr), .regs_used(regs_pr),
        .smem_used(smem_pr), .blk_used(blk_pr),
        .cost(req_cost), .fits(fits));

    // Request shape rules that apply regardless of current load.
    always_comb begin
        shape_ok = (req_threads != '0) && (32'(req_regs) <= MAX_RPT);
        req_err  = req_valid && (req_threads == '0);
        grant    = req_valid && shape_ok && fits;
    end

    AST_ZERO_THR:  assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_threads == '0) |-> (!grant && req_err));    // R8
    AST_RPT_CAP:   assert property (@(posedge clk) disable iff (!rst_n)
        (32'(req_regs) > MAX_RPT) |-> !grant);                        // R6
    AST_BLK_STEP:  assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !rel_valid) |=>
        (32'(resident_blocks) == 32'($past(resident_blocks)) + 1));   // R7
    AST_WARP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !grant) |=>
        (32'(resident_warps) < 32'($past(resident_warps))));          // R7
endmodule

// File: tb/cta_admit_ctrl_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module cta_admit_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, rel_valid = 1'b0;
    logic [11:0] req_threads = '0, rel_threads = '0;
    logic [8:0]  req_regs = '0, rel_regs = '0;
    logic [17:0] req_smem = '0, rel_smem = '0;
    logic        grant, req_err;
    logic [6:0]  resident_warps;
    logic [5:0]  resident_blocks;
    logic [16:0] regs_in_use;
    logic [17:0] smem_in_use;

    int n_tests = 0, n_fail = 0;
    bit g_s, e_s, done = 0;

    always #5 clk = ~clk;

    cta_admit_ctrl u_cta_admit_ctrl (.*);

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Present request and/or release for one cycle; capture grant/err.
    task automatic cyc(bit rv, int t, int r, int s, bit lv, int lt, int lr, int ls);
        @(negedge clk);
        req_valid = rv; req_threads = 12'(t); req_regs = 9'(r); req_smem = 18'(s);
        rel_valid = lv; rel_threads = 12'(lt); rel_regs = 9'(lr); rel_smem = 18'(ls);
        #1; g_s = grant; e_s = req_err;
        @(posedge clk); #1;
        req_valid = 0; rel_valid = 0;
    endtask

    task automatic ask(int t, int r, int s); cyc(1, t, r, s, 0, 0, 0, 0); endtask
    task automatic ret(int t, int r, int s); cyc(0, 0, 0, 0, 1, t, r, s); endtask

    task automatic chk_tot(string tag, int w, int b, int rg, int sm);
        chk({tag, " warps"}, resident_warps, w);
        chk({tag, " blocks"}, resident_blocks, b);
        chk({tag, " regs"}, regs_in_use, rg);
        chk({tag, " smem"}, smem_in_use, sm);
    endtask

    task automatic t_reset();
        chk_tot("R9 reset", 0, 0, 0, 0);
    endtask

    task automatic t_basic();
        ask(256, 64, 98304);
        chk("R7 grant basic", g_s, 1);
        chk_tot("R7 after grant", 8, 1, 16384, 98304);
        ask(33, 8, 0);
        chk("R2 grant 33 thr", g_s, 1);
        chk_tot("R2 round up", 10, 2, 16896, 98304);
        ret(256, 64, 98304);
        ret(33, 8, 0);
        chk_tot("R7 release", 0, 0, 0, 0);
    endtask

    task automatic t_regs();
        ask(512, 128, 0);
        chk("R1 exact fit", g_s, 1);
        chk_tot("R1 full file", 16, 1, 65536, 0);
        ask(32, 1, 0);
        chk("R1 over file", g_s, 0);
        chk("R1 unchanged", resident_blocks, 1);
        ask(32, 0, 0);
        chk("R1 zero-reg fits", g_s, 1);
        ret(512, 128, 0);
        ret(32, 0, 0);
        chk_tot("R1 cleared", 0, 0, 0, 0);
    endtask

    task automatic t_warps();
        ask(1024, 0, 0);
        ask(1024, 0, 0);
        chk("R3 second half", g_s, 1);
        chk("R9 occupancy full", resident_warps, 64);
        ask(1, 0, 0);
        chk("R3 warp limit", g_s, 0);
        ret(1024, 0, 0);
        chk("R9 occupancy half", resident_warps, 32);
        ret(1024, 0, 0);
    endtask

    task automatic t_blocks();
        for (int i = 0; i < 32; i++) ask(32, 0, 0);
        chk("R4 32 resident", resident_blocks, 32);
        ask(32, 0, 0);
        chk("R4 block limit", g_s, 0);
        cyc(1, 32, 0, 0, 1, 32, 0, 0);
        chk("R7 grant with release", g_s, 1);
        chk("R7 blocks steady", resident_blocks, 32);
        for (int i = 0; i < 32; i++) ret(32, 0, 0);
        chk_tot("R4 cleared", 0, 0, 0, 0);
    endtask

    task automatic t_smem();
        ask(32, 0, 233473);
        chk("R5 over alone", g_s, 0);
        ask(32, 0, 233472);
        chk("R5 exact fit", g_s, 1);
        ask(32, 0, 1);
        chk("R5 one byte over", g_s, 0);
        chk("R5 smem held", smem_in_use, 233472);
        ret(32, 0, 233472);
    endtask

    task automatic t_rpt();
        ask(32, 256, 0);
        chk("R6 256 rejected", g_s, 0);
        chk("R6 regs unchanged", regs_in_use, 0);
        ask(32, 255, 0);
        chk("R6 255 granted", g_s, 1);
        chk("R6 regs charged", regs_in_use, 8160);
        ret(32, 255, 0);
    endtask

    task automatic t_zero();
        ask(0, 8, 0);
        chk("R8 no grant", g_s, 0);
        chk("R8 err flag", e_s, 1);
        chk_tot("R8 unchanged", 0, 0, 0, 0);
        ask(32, 8, 0);
        chk("R8 err low normal", e_s, 0);
        ret(32, 8, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_regs();
        t_warps();
        t_blocks();
        t_smem();
        t_rpt();
        t_zero();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule